// File: doc/BRIEF.md
# Phase and Ramp Accumulator Stage with Event Clearing

This block is the accumulation stage of a numerically controlled oscillator, paired with a digital ramp accumulator and its rate timer. Every clock the phase register advances by a 32-bit tuning word and wraps modulo 2^32. The ramp register moves by a signed step each time a down-counting rate timer expires. It saturates at zero and at full scale instead of wrapping.

A synchronisation event is either a strobe on the update input or a change in the profile select compared with the value sampled one clock earlier. Separate control bits decide what an event does. It can clear the phase register, clear the ramp register for one cycle, or restart the rate timer. The sine/cosine select for the downstream amplitude stage is taken from its input only on an event. Everything is registered on the system clock, so an event seen at one rising edge is visible at the outputs straight after that edge.

Top module: `nco_accum_core`

## Requirements
- R1: Without a phase clear, `phase_word` after each clock edge equals its previous value plus `tune_word`, modulo 2^32.
- R2: When `phase_clr_en` is 1 and an event is sampled at an edge, `phase_word` is 0 after that edge and advances by `tune_word` from the next edge onward.
- R3: An event is `upd_strobe` = 1 or `profile_sel` differing from its value at the previous edge (0 after reset). A profile change without a strobe counts as an event.
- R4: With `ramp_en` = 1, the rate timer counts down by one per clock from `ramp_rate`. At an edge where it is 0, the ramp adds `ramp_step` and the timer reloads `ramp_rate`, giving one step every `ramp_rate`+1 clocks.
- R5: `ramp_step` is two's complement. A sum above 2^RAMP_W-1 gives 2^RAMP_W-1, and a sum below 0 gives 0.
- R6: When `ramp_clr_en` is 1 and an event is sampled, `ramp_value` is 0 after that edge. This takes priority over a step that is due at the same edge, and accumulation resumes without any other input.
- R7: When `ramp_en` and `rate_reload_en` are both 1, an event loads the timer with `ramp_rate` and no step is applied at that edge.
- R8: With `ramp_en` = 0, the ramp value and the timer hold their values, and `rate_reload_en` has no effect. The ramp clear of R6 still acts.
- R9: `sine_sel` takes `sine_sel_in` only at an edge where an event is sampled and holds otherwise. A value of 1 means sine and 0 means cosine.
- R10: Reset gives `phase_word` = 0, `ramp_value` = 0, `sine_sel` = 0 (cosine) and a rate timer of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tune_word | input | PHASE_W | Phase increment per clock |
| ramp_step | input | RAMP_W | Signed ramp increment per timer expiry |
| ramp_rate | input | RATE_W | Timer reload value |
| ramp_en | input | 1 | Enables ramp accumulation and timer |
| phase_clr_en | input | 1 | Clear phase on event |
| ramp_clr_en | input | 1 | Clear ramp for one cycle on event |
| rate_reload_en | input | 1 | Reload timer on event (needs ramp_en) |
| sine_sel_in | input | 1 | Sine/cosine choice applied on event |
| upd_strobe | input | 1 | Update strobe |
| profile_sel | input | PROF_W | Profile select; any change is an event |
| phase_word | output | PHASE_W | Phase accumulator |
| ramp_value | output | RAMP_W | Ramp accumulator |
| sine_sel | output | 1 | 1 = sine, 0 = cosine |

## Verification
The hardest case to reach is a ramp clear or timer reload that falls on the same edge as a timer expiry, or a saturating sum. Reaching the first needs an event timed to the last count of the timer. The stimulus keeps `ramp_rate` between 0 and 4 and raises events about one cycle in eight, through both strobes and profile-only changes, so such coincidences occur often. Directed runs with quarter-scale steps at rate 0 drive the ramp into both saturation limits. A directed run also disables the ramp while a reload event arrives.

// File: rtl/nco_accum_pkg.sv
package nco_accum_pkg;
    typedef enum logic [1:0] {
        RAMP_HOLD   = 2'd0,
        RAMP_STEP   = 2'd1,
        RAMP_RELOAD = 2'd2
    } ramp_act_e;
endpackage

// File: rtl/nco_evt_detect.sv
module nco_evt_detect #(
    parameter int PROF_W = 3
) (
    input  logic              upd_strobe,
    input  logic [PROF_W-1:0] profile_now,
    input  logic [PROF_W-1:0] profile_last,
    output logic              evt
);
    always_comb begin
        evt = upd_strobe | (profile_now != profile_last);
    end
endmodule

// File: rtl/nco_rate_timer_next.sv
module nco_rate_timer_next
    import nco_accum_pkg::*;
#(
    parameter int RATE_W = 16
) (
    input  logic              enable,
    input  logic              reload_req,
    input  logic [RATE_W-1:0] rate,
    input  logic [RATE_W-1:0] count_q,
    output logic [RATE_W-1:0] count_d,
    output ramp_act_e         act
);
    always_comb begin
        count_d = count_q;
        act     = RAMP_HOLD;
        if (enable) begin
            if (reload_req) begin
                count_d = rate;
                act     = RAMP_RELOAD;
            end else if (count_q == '0) begin
                count_d = rate;
                act     = RAMP_STEP;
            end else begin
                count_d = count_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/nco_ramp_sat.sv
module nco_ramp_sat #(
    parameter int RAMP_W = 32
) (
    input  logic [RAMP_W-1:0] acc,
    input  logic [RAMP_W-1:0] step,
    output logic [RAMP_W-1:0] sum
);
    localparam int EXT_W = RAMP_W + 2;
    logic [EXT_W-1:0] wide;

    always_comb begin
        wide = {2'b00, acc} + {{2{step[RAMP_W-1]}}, step};
        if (wide[EXT_W-1]) begin
            sum = '0;
        end else if (wide[RAMP_W]) begin
            sum = '1;
        end else begin
            sum = wide[RAMP_W-1:0];
        end
    end
endmodule

// File: rtl/nco_accum_core.sv
module nco_accum_core
    import nco_accum_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int RAMP_W  = 32,
    parameter int RATE_W  = 16,
    parameter int PROF_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] tune_word,
    input  logic [RAMP_W-1:0]  ramp_step,
    input  logic [RATE_W-1:0]  ramp_rate,
    input  logic               ramp_en,
    input  logic               phase_clr_en,
    input  logic               ramp_clr_en,
    input  logic               rate_reload_en,
    input  logic               sine_sel_in,
    input  logic               upd_strobe,
    input  logic [PROF_W-1:0]  profile_sel,
    output logic [PHASE_W-1:0] phase_word,
    output logic [RAMP_W-1:0]  ramp_value,
    output logic               sine_sel
);
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic [RAMP_W-1:0]  ramp;
        logic [RATE_W-1:0]  timer;
        logic [PROF_W-1:0]  prof;
        logic               sel;
    } state_t;

    state_t    st_q;
    state_t    st_d;
    logic      evt;
    logic      reload_req;
    logic [RATE_W-1:0] timer_next;
    ramp_act_e act;
    logic [RAMP_W-1:0] ramp_sum;

    nco_evt_detect #(.PROF_W(PROF_W)) i_evt (
        .upd_strobe   (upd_strobe),
        .profile_now  (profile_sel),
        .profile_last (st_q.prof),
        .evt          (evt)
    );

    assign reload_req = rate_reload_en & evt;

    nco_rate_timer_next #(.RATE_W(RATE_W)) i_timer (
        .enable     (ramp_en),
        .reload_req (reload_req),
        .rate       (ramp_rate),
        .count_q    (st_q.timer),
        .count_d    (timer_next),
        .act        (act)
    );

    nco_ramp_sat #(.RAMP_W(RAMP_W)) i_sat (
        .acc  (st_q.ramp),
        .step (ramp_step),
        .sum  (ramp_sum)
    );

    always_comb begin
        st_d       = st_q;
        st_d.prof  = profile_sel;
        st_d.timer = timer_next;

        if (evt && phase_clr_en) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + tune_word;
        end

        if (evt && ramp_clr_en) begin
            st_d.ramp = '0;
        end else if (act == RAMP_STEP) begin
            st_d.ramp = ramp_sum;
        end

        if (evt) begin
            st_d.sel = sine_sel_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_word = st_q.phase;
    assign ramp_value = st_q.ramp;
    assign sine_sel   = st_q.sel;
endmodule

// File: rtl/nco_accum_checker.sv
module nco_accum_checker #(
    parameter int PHASE_W = 32,
    parameter int RAMP_W  = 32,
    parameter int RATE_W  = 16,
    parameter int PROF_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PHASE_W-1:0] tune_word,
    input logic               ramp_en,
    input logic               phase_clr_en,
    input logic               ramp_clr_en,
    input logic               upd_strobe,
    input logic [PROF_W-1:0]  profile_sel,
    input logic [PHASE_W-1:0] phase_word,
    input logic [RAMP_W-1:0]  ramp_value,
    input logic               sine_sel
);
    logic [PROF_W-1:0] prof_seen;
    logic              ev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prof_seen <= '0;
        else        prof_seen <= profile_sel;
    end

    assign ev = upd_strobe || (profile_sel != prof_seen);

    assert_phase_add_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev && phase_clr_en) |=> phase_word == $past(phase_word + tune_word));

    assert_phase_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && phase_clr_en) |=> phase_word == '0);

    assert_ramp_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && ramp_clr_en) |=> ramp_value == '0);

    assert_ramp_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ramp_en && !(ev && ramp_clr_en)) |=> $stable(ramp_value));

    assert_sel_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ev |=> $stable(sine_sel));
endmodule

bind nco_accum_core nco_accum_checker #(
    .PHASE_W(PHASE_W), .RAMP_W(RAMP_W), .RATE_W(RATE_W), .PROF_W(PROF_W)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tune_word    (tune_word),
    .ramp_en      (ramp_en),
    .phase_clr_en (phase_clr_en),
    .ramp_clr_en  (ramp_clr_en),
    .upd_strobe   (upd_strobe),
    .profile_sel  (profile_sel),
    .phase_word   (phase_word),
    .ramp_value   (ramp_value),
    .sine_sel     (sine_sel)
);

// File: tb/test_nco_accum_core.sv
module test_nco_accum_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tune_word = '0;
    logic [31:0] ramp_step = '0;
    logic [15:0] ramp_rate = '0;
    logic        ramp_en = 1'b0;
    logic        phase_clr_en = 1'b0;
    logic        ramp_clr_en = 1'b0;
    logic        rate_reload_en = 1'b0;
    logic        sine_sel_in = 1'b0;
    logic        upd_strobe = 1'b0;
    logic [2:0]  profile_sel = '0;
    logic [31:0] phase_word;
    logic [31:0] ramp_value;
    logic        sine_sel;

    int total = 0;
    int bad = 0;
    bit done = 0;

    bit [31:0] m_phase = 0;
    longint    m_ramp = 0;
    int        m_timer = 0;
    bit        m_sel = 0;
    bit [2:0]  m_prof = 0;
    string     ph_tag;
    string     rp_tag;

    always #4 clk = ~clk;

    nco_accum_core i_nco_accum_core (
        .clk(clk), .rst_n(rst_n), .tune_word(tune_word), .ramp_step(ramp_step),
        .ramp_rate(ramp_rate), .ramp_en(ramp_en), .phase_clr_en(phase_clr_en),
        .ramp_clr_en(ramp_clr_en), .rate_reload_en(rate_reload_en),
        .sine_sel_in(sine_sel_in), .upd_strobe(upd_strobe), .profile_sel(profile_sel),
        .phase_word(phase_word), .ramp_value(ramp_value), .sine_sel(sine_sel)
    );

    function automatic longint sat_add(longint a, bit [31:0] s);
        longint r = a + longint'($signed(s));
        if (r < 0) return 0;
        if (r > 64'hFFFF_FFFF) return 64'hFFFF_FFFF;
        return r;
    endfunction

    task automatic check(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance the model by one edge using the inputs now driven, then compare.
    task automatic cyc();
        bit ev;
        bit stepnow = 0;
        bit prof_only;
        ev = upd_strobe || (profile_sel != m_prof);
        prof_only = !upd_strobe && ev;
        m_prof = profile_sel;
        ph_tag = (ev && phase_clr_en) ? (prof_only ? "R3" : "R2") : "R1";
        if (ev && phase_clr_en) m_phase = 0;
        else m_phase = m_phase + tune_word;
        if (ev) m_sel = sine_sel_in;
        rp_tag = "R4";
        if (ramp_en) begin
            if (rate_reload_en && ev) begin
                m_timer = int'(ramp_rate);
                rp_tag = "R7";
            end else if (m_timer == 0) begin
                stepnow = 1;
                m_timer = int'(ramp_rate);
            end else begin
                m_timer--;
            end
        end else begin
            rp_tag = "R8";
        end
        if (ev && ramp_clr_en) begin
            m_ramp = 0;
            rp_tag = "R6";
        end else if (stepnow) begin
            longint raw = m_ramp + longint'($signed(ramp_step));
            if (raw < 0 || raw > 64'hFFFF_FFFF) rp_tag = "R5";
            m_ramp = sat_add(m_ramp, ramp_step);
        end
        @(negedge clk);
        check(ph_tag, longint'(phase_word), longint'(m_phase));
        check(rp_tag, longint'(ramp_value), m_ramp);
        check("R9", longint'(sine_sel), longint'(m_sel));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd11));
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", longint'(phase_word), 0);
        check("R10", longint'(ramp_value), 0);
        check("R10", longint'(sine_sel), 0);
        rst_n = 1'b1;

        // R1: plain phase accumulation with wrap
        tune_word = 32'hC000_0001;
        repeat (6) cyc();

        // R3: profile-only change clears phase when enabled
        phase_clr_en = 1'b1;
        profile_sel = 3'd5;
        cyc();
        cyc();
        phase_clr_en = 1'b0;

        // R5: saturate high then low at rate 0
        ramp_en = 1'b1;
        ramp_rate = 16'd0;
        ramp_step = 32'h4000_0000;
        repeat (6) cyc();
        ramp_step = 32'hC000_0000;
        repeat (6) cyc();

        // R8: disabled ramp ignores reload event, then resumes from frozen timer
        ramp_step = 32'd100;
        ramp_rate = 16'd3;
        repeat (2) cyc();
        ramp_en = 1'b0;
        rate_reload_en = 1'b1;
        upd_strobe = 1'b1;
        cyc();
        upd_strobe = 1'b0;
        repeat (3) cyc();
        ramp_en = 1'b1;
        repeat (6) cyc();
        rate_reload_en = 1'b0;

        // Random mix: R2, R4, R6, R7, R9 coincidences
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 31) == 0) begin
                ramp_en        = ($urandom_range(0, 3) != 0);
                phase_clr_en   = $urandom_range(0, 1) == 1;
                ramp_clr_en    = $urandom_range(0, 1) == 1;
                rate_reload_en = $urandom_range(0, 1) == 1;
                ramp_rate      = 16'($urandom_range(0, 4));
                ramp_step      = $urandom();
                tune_word      = $urandom();
            end
            sine_sel_in = $urandom_range(0, 1) == 1;
            upd_strobe  = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 15) == 0) profile_sel = 3'($urandom_range(0, 7));
            cyc();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule